// File: doc/BRIEF.md
# Indexed Gather-Scatter Address Generator

This block walks an indexed memory kernel with a single level of indirection and produces, for every request strobe, two addresses: one into the index array and one into the value array. The index array is read in a plain linear sweep. The value element is found differently. The block takes the iteration number times a stride and adds one offset from a short pattern. That pattern rotates by one entry on every access, and one full turn of the pattern makes one iteration.

Before a kernel runs, software-side logic writes the offset pattern through a simple write port. It then sets the pattern length, both base addresses, both element sizes, the stride, the iteration count and the kernel kind (gather reads values, scatter writes them). A start pulse rewinds the walk. After that, each accepted strobe yields one registered address pair with a valid pulse one cycle later. When the configured number of iterations is complete, `done` goes high and any further strobes are dropped.

Top module: `igs_addr_gen`

## Requirements
- R1: After reset, `out_valid` is low and the walk counters are zero, so `done` is low whenever `cfg_count` is non-zero.
- R2: The index address of the n-th accepted strobe since start (n from 0) is `cfg_idx_base + n * cfg_idx_size`, modulo 2^32. n keeps counting across iterations and does not wrap.
- R3: The value element is `cfg_delta * iter + offset`, modulo 2^32. The value address is `cfg_val_base + element * cfg_val_size`, modulo 2^32.
- R4: The offset used by the k-th access of an iteration (k from 0) is pattern entry k. Entries occupy write addresses 0 to L-1, where L is `cfg_pat_len` (1..16; 0 acts as 1).
- R5: The iteration number advances by one after every L accepted strobes.
- R6: `done` is high exactly when the iteration number equals `cfg_count`. It rises in the same cycle as the `out_valid` of the last access of the final iteration.
- R7: A strobe taken while `done` is high produces no `out_valid` and leaves the walk unchanged.
- R8: `out_val_write` is 1 (write) for a scatter kernel (`cfg_scatter`=1) and 0 (read) for a gather kernel. The index access is always a read.
- R9: `out_valid` pulses for one cycle, exactly one cycle after each accepted strobe, and at no other time.
- R10: A `start` pulse clears the index, iteration and pattern-position state. A strobe in the same cycle as `start` is dropped.
- R11: With `pat_we` high, `pat_wdata` is stored into pattern entry `pat_waddr` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx_base | input | 32 | Index array base address |
| cfg_idx_size | input | 8 | Index element size in bytes |
| cfg_val_base | input | 32 | Value array base address |
| cfg_val_size | input | 8 | Value element size in bytes |
| cfg_delta | input | 32 | Per-iteration element stride |
| cfg_count | input | 32 | Number of iterations in the kernel |
| cfg_scatter | input | 1 | 1 = scatter (value write), 0 = gather (value read) |
| cfg_pat_len | input | 5 | Number of active pattern entries |
| pat_we | input | 1 | Pattern write enable |
| pat_waddr | input | 4 | Pattern entry to write |
| pat_wdata | input | 32 | Offset written into the pattern |
| start | input | 1 | Rewinds the walk to its first access |
| next | input | 1 | Request strobe for one address pair |
| out_valid | output | 1 | Address pair valid |
| out_idx_addr | output | 32 | Index-array read address |
| out_val_addr | output | 32 | Value-array address |
| out_val_write | output | 1 | Value access is a write |
| done | output | 1 | All iterations issued |

## Verification
Two things can fall in the same cycle: the final access of the last iteration, and the completion flag. The pattern wrap that advances the iteration also makes `done` true, so `done` must rise in exactly the cycle that carries the last valid pair. The bench provokes this with back-to-back strobes across several pattern lengths, including a one-entry pattern where every access wraps. A scoreboard stores the expected `done` value with each expected pair, and the check is made in the cycle the pair appears. A second collision is `start` arriving together with a strobe. The bench checks that no pair comes out and that the next strobe returns the first address of the kernel.

// File: rtl/igs_pkg.sv
package igs_pkg;

    localparam int ADDR_W    = 32;
    localparam int OFF_W     = 32;
    localparam int CNT_W     = 32;
    localparam int SZ_W      = 8;
    localparam int PAT_DEPTH = 16;
    localparam int PTR_W     = $clog2(PAT_DEPTH);
    localparam int LEN_W     = $clog2(PAT_DEPTH + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SZ_W-1:0]   esize_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef enum logic {
        VAL_READ  = 1'b0,
        VAL_WRITE = 1'b1
    } val_op_e;

    typedef struct packed {
        addr_t   idx_addr;
        addr_t   val_addr;
        val_op_e op;
    } pair_t;

    function automatic addr_t calc_idx_addr(addr_t base, cnt_t n, esize_t sz);
        return base + addr_t'(n) * addr_t'(sz);
    endfunction

    function automatic off_t calc_val_elem(off_t delta, cnt_t iter, off_t off);
        return delta * off_t'(iter) + off;
    endfunction

    function automatic addr_t calc_val_addr(addr_t base, off_t elem, esize_t sz);
        return base + addr_t'(elem) * addr_t'(sz);
    endfunction

    function automatic len_t clamp_len(len_t len);
        if (len == '0)
            return len_t'(1);
        else if (len > len_t'(PAT_DEPTH))
            return len_t'(PAT_DEPTH);
        else
            return len;
    endfunction

endpackage

// File: rtl/igs_pattern_ring.sv
module igs_pattern_ring
    import igs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  ptr_t wr_addr,
    input  off_t wr_data,
    input  logic rewind,
    input  logic advance,
    input  len_t len,
    output off_t head_off
);

    off_t                 slots [PAT_DEPTH];
    logic [PAT_DEPTH-1:0] wr_sel;
    ptr_t                 head_q;
    ptr_t                 last_pos;

    // one-hot write decode, one select per entry
    for (genvar g = 0; g < PAT_DEPTH; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_addr == ptr_t'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PAT_DEPTH; i++) slots[i] <= '0;
        end else begin
            for (int i = 0; i < PAT_DEPTH; i++) begin
                if (wr_sel[i]) slots[i] <= wr_data;
            end
        end
    end

    assign last_pos = ptr_t'(len - len_t'(1));

    // rotating head: moving the head offset to the tail is the same as
    // stepping a read pointer around the active entries
    always_ff @(posedge clk) begin
        if (rst || rewind)
            head_q <= '0;
        else if (advance)
            head_q <= (head_q == last_pos) ? '0 : head_q + ptr_t'(1);
    end

    assign head_off = slots[head_q];

endmodule

// File: rtl/igs_walk_ctr.sv
module igs_walk_ctr
    import igs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rewind,
    input  logic advance,
    input  len_t len,
    input  cnt_t count,
    output cnt_t idx_cnt,
    output cnt_t iter,
    output logic finished
);

    cnt_t idx_q;
    cnt_t iter_q;
    len_t rolls_q;

    always_ff @(posedge clk) begin
        if (rst || rewind) begin
            idx_q   <= '0;
            iter_q  <= '0;
            rolls_q <= len;
        end else if (advance) begin
            idx_q <= idx_q + cnt_t'(1);
            if (rolls_q <= len_t'(1)) begin
                rolls_q <= len;
                iter_q  <= iter_q + cnt_t'(1);
            end else begin
                rolls_q <= rolls_q - len_t'(1);
            end
        end
    end

    assign idx_cnt  = idx_q;
    assign iter     = iter_q;
    assign finished = (iter_q == count);

endmodule

// File: rtl/igs_addr_out.sv
module igs_addr_out
    import igs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  pair_t pair_d,
    output logic  valid,
    output pair_t pair_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            pair_q <= '0;
        end else begin
            valid <= fire;
            if (fire) pair_q <= pair_d;
        end
    end

endmodule

// File: rtl/igs_addr_gen.sv
module igs_addr_gen
    import igs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_idx_base,
    input  logic [SZ_W-1:0]     cfg_idx_size,
    input  logic [ADDR_W-1:0]   cfg_val_base,
    input  logic [SZ_W-1:0]     cfg_val_size,
    input  logic [OFF_W-1:0]    cfg_delta,
    input  logic [CNT_W-1:0]    cfg_count,
    input  logic                cfg_scatter,
    input  logic [LEN_W-1:0]    cfg_pat_len,
    input  logic                pat_we,
    input  logic [PTR_W-1:0]    pat_waddr,
    input  logic [OFF_W-1:0]    pat_wdata,
    input  logic                start,
    input  logic                next,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_idx_addr,
    output logic [ADDR_W-1:0]   out_val_addr,
    output logic                out_val_write,
    output logic                done
);

    len_t  len_eff;
    logic  fire;
    off_t  head_off;
    cnt_t  idx_cnt;
    cnt_t  iter;
    off_t  elem;
    pair_t pair_d;
    pair_t pair_q;

    assign len_eff = clamp_len(cfg_pat_len);
    // start has priority; a finished kernel drops strobes
    assign fire    = next && !done && !start;

    igs_pattern_ring u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (pat_we),
        .wr_addr  (pat_waddr),
        .wr_data  (pat_wdata),
        .rewind   (start),
        .advance  (fire),
        .len      (len_eff),
        .head_off (head_off)
    );

    igs_walk_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .rewind   (start),
        .advance  (fire),
        .len      (len_eff),
        .count    (cfg_count),
        .idx_cnt  (idx_cnt),
        .iter     (iter),
        .finished (done)
    );

    always_comb begin
        elem            = calc_val_elem(cfg_delta, iter, head_off);
        pair_d.idx_addr = calc_idx_addr(cfg_idx_base, idx_cnt, cfg_idx_size);
        pair_d.val_addr = calc_val_addr(cfg_val_base, elem, cfg_val_size);
        pair_d.op       = cfg_scatter ? VAL_WRITE : VAL_READ;
    end

    igs_addr_out u_out (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .pair_d (pair_d),
        .valid  (out_valid),
        .pair_q (pair_q)
    );

    assign out_idx_addr  = pair_q.idx_addr;
    assign out_val_addr  = pair_q.val_addr;
    assign out_val_write = (pair_q.op == VAL_WRITE);

endmodule

// File: rtl/igs_addr_gen_chk.sv
module igs_addr_gen_chk
    import igs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SZ_W-1:0]   cfg_idx_size,
    input logic [CNT_W-1:0]  cfg_count,
    input logic              cfg_scatter,
    input logic              start,
    input logic              next,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_idx_addr,
    input logic              out_val_write,
    input logic              done
);

    // R9: a valid pair only ever follows an accepted strobe
    assert_valid_follows_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(next && !done && !start));

    // R7: strobes while finished are dropped
    assert_no_issue_when_done_R7: assert property (@(posedge clk) disable iff (rst)
        (done && next && !start) |=> !out_valid);

    // R10: start beats a simultaneous strobe
    assert_start_drops_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> !out_valid);

    // R2: back-to-back accepted strobes step the index address by one element
    assert_index_step_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && next && !done && !start)
        |=> (out_idx_addr == $past(out_idx_addr) + ADDR_W'($past(cfg_idx_size))));

    // R8: access kind follows the kernel type
    assert_op_kind_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_val_write == $past(cfg_scatter)));

    // R6: completion appears together with the final pair
    assert_done_with_last_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && $past(!start) && $stable(cfg_count)) |-> out_valid);

endmodule

bind igs_addr_gen igs_addr_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_idx_size  (cfg_idx_size),
    .cfg_count     (cfg_count),
    .cfg_scatter   (cfg_scatter),
    .start         (start),
    .next          (next),
    .out_valid     (out_valid),
    .out_idx_addr  (out_idx_addr),
    .out_val_write (out_val_write),
    .done          (done)
);

// File: tb/igs_addr_gen_bench.sv
module igs_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_idx_base = '0;
    logic [7:0]  cfg_idx_size = '0;
    logic [31:0] cfg_val_base = '0;
    logic [7:0]  cfg_val_size = '0;
    logic [31:0] cfg_delta = '0;
    logic [31:0] cfg_count = 32'd3;
    logic        cfg_scatter = 1'b0;
    logic [4:0]  cfg_pat_len = 5'd1;
    logic        pat_we = 1'b0;
    logic [3:0]  pat_waddr = '0;
    logic [31:0] pat_wdata = '0;
    logic        start = 1'b0;
    logic        next = 1'b0;
    logic        out_valid;
    logic [31:0] out_idx_addr;
    logic [31:0] out_val_addr;
    logic        out_val_write;
    logic        done;

    always #4 clk = ~clk;   // 125 MHz

    igs_addr_gen u_igs_addr_gen (
        .clk(clk), .rst(rst),
        .cfg_idx_base(cfg_idx_base), .cfg_idx_size(cfg_idx_size),
        .cfg_val_base(cfg_val_base), .cfg_val_size(cfg_val_size),
        .cfg_delta(cfg_delta), .cfg_count(cfg_count),
        .cfg_scatter(cfg_scatter), .cfg_pat_len(cfg_pat_len),
        .pat_we(pat_we), .pat_waddr(pat_waddr), .pat_wdata(pat_wdata),
        .start(start), .next(next),
        .out_valid(out_valid), .out_idx_addr(out_idx_addr),
        .out_val_addr(out_val_addr), .out_val_write(out_val_write),
        .done(done)
    );

    typedef struct {
        logic [31:0] ia;
        logic [31:0] va;
        logic        wr;
        logic        dn;
    } exp_t;

    exp_t        sb_q[$];
    exp_t        mon_e;
    int          n_checks = 0;
    int          n_errors = 0;
    int          n_valid  = 0;
    bit          finished = 0;

    // reference model state
    logic [31:0] m_pat [16];
    logic [31:0] m_idx, m_iter;
    int          m_pos;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic int eff_len();
        return (cfg_pat_len == 0) ? 1 : int'(cfg_pat_len);
    endfunction

    task automatic write_pat(input int a, input logic [31:0] d);
        pat_we = 1'b1; pat_waddr = 4'(a); pat_wdata = d;
        m_pat[a] = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic model_rewind();
        m_idx = '0; m_iter = '0; m_pos = 0;
    endtask

    task automatic do_start();
        start = 1'b1;
        model_rewind();
        @(negedge clk);
        start = 1'b0;
    endtask

    // driver: raises the strobe and queues what the requirements predict
    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            next = 1'b1;
            if (m_iter != cfg_count) begin
                e.ia = cfg_idx_base + m_idx * 32'(cfg_idx_size);
                e.va = cfg_val_base + (cfg_delta * m_iter + m_pat[m_pos]) * 32'(cfg_val_size);
                e.wr = cfg_scatter;
                m_idx = m_idx + 1;
                m_pos = m_pos + 1;
                if (m_pos == eff_len()) begin
                    m_pos  = 0;
                    m_iter = m_iter + 1;
                end
                e.dn = (m_iter == cfg_count);
                sb_q.push_back(e);
            end
            @(negedge clk);
        end
        next = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares each produced pair with the queue head
    always @(posedge clk) begin
        #2;
        if (!rst && out_valid) begin
            n_valid++;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 valid without accepted strobe", 32'd1, 32'd0);
            end else begin
                mon_e = sb_q.pop_front();
                chk(out_idx_addr == mon_e.ia, "R2 index address", out_idx_addr, mon_e.ia);
                chk(out_val_addr == mon_e.va, "R3 R4 R5 R11 value address", out_val_addr, mon_e.va);
                chk(out_val_write == mon_e.wr, "R8 access kind", 32'(out_val_write), 32'(mon_e.wr));
                chk(done == mon_e.dn, "R6 done with final pair", 32'(done), 32'(mon_e.dn));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int saved;
        for (int i = 0; i < 16; i++) m_pat[i] = '0;
        model_rewind();
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        chk(done == 1'b0, "R1 done after reset with count 3", 32'(done), 32'd0);

        // gather, four-entry pattern, back-to-back strobes
        write_pat(0, 32'd3); write_pat(1, 32'd0); write_pat(2, 32'd7); write_pat(3, 32'd1);
        cfg_idx_base = 32'h0000_1000; cfg_idx_size = 8'd4;
        cfg_val_base = 32'h0000_8000; cfg_val_size = 8'd8;
        cfg_delta = 32'd10; cfg_count = 32'd3; cfg_pat_len = 5'd4; cfg_scatter = 1'b0;
        do_start();
        strobe(12);
        idle(2);
        chk(done == 1'b1, "R6 done after all iterations", 32'(done), 32'd1);
        // R7 strobes while finished
        saved = n_valid;
        strobe(3);
        idle(3);
        chk(n_valid == saved, "R7 no pair while done", 32'(n_valid), 32'(saved));
        chk(done == 1'b1, "R7 walk unchanged while done", 32'(done), 32'd1);

        // scatter, one-entry pattern, strobes with gaps
        write_pat(0, 32'd5);
        cfg_scatter = 1'b1; cfg_pat_len = 5'd1; cfg_delta = 32'd2; cfg_count = 32'd5;
        cfg_idx_size = 8'd2; cfg_val_size = 8'd4;
        do_start();
        chk(done == 1'b0, "R10 start rewinds walk", 32'(done), 32'd0);
        for (int k = 0; k < 5; k++) begin
            strobe(1);
            idle(k);
        end
        idle(2);

        // full sixteen-entry pattern, wrapping value addresses
        for (int i = 0; i < 16; i++) write_pat(i, 32'h0100_0000 * i + 32'(i * 3));
        cfg_scatter = 1'b0; cfg_pat_len = 5'd16; cfg_delta = 32'd100; cfg_count = 32'd2;
        cfg_val_base = 32'hFFFF_FF00; cfg_val_size = 8'h40;
        cfg_idx_base = 32'hFFFF_FFF0; cfg_idx_size = 8'd8;
        do_start();
        strobe(20);
        idle(2);

        // length 0 acts as 1
        write_pat(0, 32'd9);
        cfg_pat_len = 5'd0; cfg_count = 32'd2; cfg_delta = 32'd1;
        do_start();
        strobe(3);
        idle(2);

        // R10 start together with a strobe
        cfg_pat_len = 5'd4; cfg_count = 32'd2;
        write_pat(0, 32'd3); write_pat(1, 32'd0); write_pat(2, 32'd7); write_pat(3, 32'd1);
        strobe(2);
        idle(1);
        saved = n_valid;
        start = 1'b1; next = 1'b1;
        model_rewind();
        @(negedge clk);
        start = 1'b0; next = 1'b0;
        idle(2);
        chk(n_valid == saved, "R10 strobe dropped on start", 32'(n_valid), 32'(saved));
        strobe(8);
        idle(2);

        // count 0: finished at once, strobe ignored
        cfg_count = 32'd0;
        do_start();
        chk(done == 1'b1, "R6 done with zero count", 32'(done), 32'd1);
        saved = n_valid;
        strobe(2);
        idle(2);
        chk(n_valid == saved, "R7 zero-count strobe ignored", 32'(n_valid), 32'(saved));

        chk(sb_q.size() == 0, "R9 every accepted strobe answered", 32'(sb_q.size()), 32'd0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule